// File: doc/BRIEF.md
# Reset Request Qualifier and Sequencer

This block turns an asynchronous, active-high reset request pin into a clean internal reset for an 8-bit controller core. It also gives a reset output that peripherals can share. The pin passes through a two-flop synchroniser. A small state machine then measures how long the pin stays high, counting system clocks. Only a pulse that reaches the minimum width for the selected clock source is accepted.

- With the high-frequency oscillator selected, the minimum width is two machine cycles. One machine cycle is twelve clocks.
- With the PLL selected, the minimum width is a separate clock-count parameter, standing for one microsecond.
- A one-cycle overflow strobe from a watchdog timer starts a fixed pulse of three machine cycles. The reset output is high while either the qualified pin reset or that pulse is active.
- While reset is active, the address-latch strobe and the program-store strobe are forced high.
- No memory clear is sequenced, because the core's data RAM keeps its contents through reset.

The qualifier has three states: `Q_IDLE`, `Q_MEASURE` and `Q_HELD`. Its transitions are:

- `Q_IDLE`→`Q_MEASURE` on the first high sample. It goes straight to `Q_HELD` if the width is one clock.
- `Q_MEASURE`→`Q_MEASURE` while the pin is high and the count is short of the width.
- `Q_MEASURE`→`Q_HELD` on the sample that reaches the width.
- `Q_MEASURE`→`Q_IDLE` on any low sample.
- `Q_HELD`→`Q_HELD` while the pin is high.
- `Q_HELD`→`Q_IDLE` on the first low sample.

Top module: `reset_sequencer`

## Requirements
- R1: While `arst_n` is low, `core_rst_o` and `rst_out_o` are 0, and `ale_o`/`psen_o` equal `ale_i`/`psen_i`.
- R2: `rst_req_i` goes through two synchronising flops. The qualifier sees the pin value two rising edges after it was driven.
- R3: With `pll_sel_i`=0, the pin reset asserts on the edge at which the synchronised pin has been sampled high on 24 consecutive edges (2 × 12 clocks).
- R4: With `pll_sel_i`=1, the width is `PLL_CLKS` consecutive high samples (default 100).
- R5: A synchronised pulse shorter than the selected width causes no reset. A single low sample restarts the measurement from zero.
- R6: Once asserted, the pin reset stays high while the synchronised pin is high. It drops on the first edge that samples it low.
- R7: A `wdt_ovf_i` strobe sampled at an edge makes the watchdog pulse high for exactly 36 clocks (3 × 12), starting at that edge.
- R8: A strobe that arrives while the pulse is running reloads it to a full 36 clocks.
- R9: `core_rst_o` and `rst_out_o` are both the OR of the pin reset and the watchdog pulse.
- R10: While `core_rst_o` is 1, `ale_o` and `psen_o` are 1. Otherwise they follow `ale_i` and `psen_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous clear of the block's own flops, active low |
| rst_req_i | input | 1 | Asynchronous reset request pin, active high |
| pll_sel_i | input | 1 | Clock source: 0 high-frequency oscillator, 1 PLL |
| wdt_ovf_i | input | 1 | Single-cycle watchdog overflow strobe |
| ale_i | input | 1 | Address-latch strobe from the core |
| psen_i | input | 1 | Program-store strobe from the core |
| core_rst_o | output | 1 | Internal reset to the CPU |
| rst_out_o | output | 1 | Reset output for peripherals |
| ale_o | output | 1 | Address-latch strobe to the pin |
| psen_o | output | 1 | Program-store strobe to the pin |

## Verification
The assertions take for granted that `pll_sel_i` is static while a pin pulse is being measured. The rise check for the qualifier only bounds the count from below by the smaller of the two widths. The watchdog input is assumed to be a synchronous strobe. The bench changes `pll_sel_i` only while the pin has been low for several cycles, and drives `wdt_ovf_i` on falling edges as one-cycle pulses.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        Q_IDLE    = 2'd0,
        Q_MEASURE = 2'd1,
        Q_HELD    = 2'd2
    } qual_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain_q[s] <= 1'b0;
                    else         chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_pin_qual.sv
module rst_pin_qual
    import rstseq_pkg::*;
#(
    parameter int unsigned HF_CLKS  = 24,
    parameter int unsigned PLL_CLKS = 100
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sync_i,
    input  logic pll_sel_i,
    output logic qual_o
);
    localparam int unsigned MAXW = max_u(HF_CLKS, PLL_CLKS);
    localparam int unsigned MINW = min_u(HF_CLKS, PLL_CLKS);
    localparam int unsigned CW   = $clog2(MAXW + 1);

    qual_state_e     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   need_w;

    assign need_w = pll_sel_i ? CW'(PLL_CLKS) : CW'(HF_CLKS);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            Q_IDLE: begin
                if (sync_i) begin
                    cnt_d   = CW'(1);
                    state_d = (need_w <= CW'(1)) ? Q_HELD : Q_MEASURE;
                end
            end
            Q_MEASURE: begin
                if (!sync_i) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q >= need_w - CW'(1)) begin
                    state_d = Q_HELD;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            Q_HELD: begin
                if (!sync_i) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = Q_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= Q_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        qual_o = (state_q == Q_HELD);
    end

    // Independent run-length observer used only by the checks below.
    logic [CW-1:0] obs_run_q;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                    obs_run_q <= '0;
        else if (!sync_i)               obs_run_q <= '0;
        else if (obs_run_q != CW'(MAXW)) obs_run_q <= obs_run_q + CW'(1);
    end

    a_r5_no_early_rise: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(qual_o) |-> (obs_run_q >= CW'(MINW)));

    a_r6_low_drops: assert property (@(posedge clk) disable iff (!arst_n)
        !sync_i |=> !qual_o);

    a_r6_high_holds: assert property (@(posedge clk) disable iff (!arst_n)
        (qual_o && sync_i) |=> qual_o);
endmodule

// File: rtl/rst_wdt_pulse.sv
module rst_wdt_pulse #(
    parameter int unsigned PULSE_CLKS = 36
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ovf_i,
    output logic active_o
);
    localparam int unsigned CW = $clog2(PULSE_CLKS + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)              left_q <= '0;
        else if (ovf_i)           left_q <= CW'(PULSE_CLKS);
        else if (left_q != '0)    left_q <= left_q - CW'(1);
    end

    assign active_o = (left_q != '0);

    a_r8_reload_full: assert property (@(posedge clk) disable iff (!arst_n)
        ovf_i |=> (left_q == CW'(PULSE_CLKS)));

    a_r7_keeps_running: assert property (@(posedge clk) disable iff (!arst_n)
        (active_o && left_q != CW'(1)) |=> active_o);

    a_r7_ends_quiet: assert property (@(posedge clk) disable iff (!arst_n)
        (!active_o && !ovf_i) |=> !active_o);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int unsigned MC_CLKS  = 12,
    parameter int unsigned HF_MC    = 2,
    parameter int unsigned WDT_MC   = 3,
    parameter int unsigned PLL_CLKS = 100,
    parameter int unsigned SYNC_STG = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_req_i,
    input  logic pll_sel_i,
    input  logic wdt_ovf_i,
    input  logic ale_i,
    input  logic psen_i,
    output logic core_rst_o,
    output logic rst_out_o,
    output logic ale_o,
    output logic psen_o
);
    localparam int unsigned HF_CLKS  = HF_MC * MC_CLKS;
    localparam int unsigned WDT_CLKS = WDT_MC * MC_CLKS;

    logic req_sync;
    logic pin_rst;
    logic wdt_rst;

    rst_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    (rst_req_i),
        .q_o    (req_sync)
    );

    rst_pin_qual #(.HF_CLKS(HF_CLKS), .PLL_CLKS(PLL_CLKS)) u_qual (
        .clk       (clk),
        .arst_n    (arst_n),
        .sync_i    (req_sync),
        .pll_sel_i (pll_sel_i),
        .qual_o    (pin_rst)
    );

    rst_wdt_pulse #(.PULSE_CLKS(WDT_CLKS)) u_wdt (
        .clk      (clk),
        .arst_n   (arst_n),
        .ovf_i    (wdt_ovf_i),
        .active_o (wdt_rst)
    );

    always_comb begin
        core_rst_o = pin_rst | wdt_rst;
        rst_out_o  = core_rst_o;
        ale_o      = ale_i  | core_rst_o;
        psen_o     = psen_i | core_rst_o;
    end

    a_r10_strobes_high: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst_o |-> (ale_o && psen_o));

    a_r2_rise_needs_sync: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(pin_rst) |-> $past(req_sync));

    a_r9_wdt_reaches_out: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_ovf_i |=> rst_out_o);
endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;
    localparam int HF_W  = 24;
    localparam int PLL_W = 100;
    localparam int WDT_W = 36;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic rst_req_i = 1'b0, pll_sel_i = 1'b0, wdt_ovf_i = 1'b0;
    logic ale_i = 1'b0, psen_i = 1'b0;
    logic core_rst_o, rst_out_o, ale_o, psen_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m_run = 0, m_wc = 0;
    bit m_s1 = 0, m_s2 = 0, m_q = 0;
    int seen_high;

    always #5 clk = ~clk;

    reset_sequencer u0 (
        .clk(clk), .arst_n(arst_n), .rst_req_i(rst_req_i), .pll_sel_i(pll_sel_i),
        .wdt_ovf_i(wdt_ovf_i), .ale_i(ale_i), .psen_i(psen_i),
        .core_rst_o(core_rst_o), .rst_out_o(rst_out_o), .ale_o(ale_o), .psen_o(psen_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model at rising edge, compare just after.
    task automatic step(input logic p, input logic w);
        logic exp;
        int width;
        @(negedge clk);
        rst_req_i = p;
        wdt_ovf_i = w;
        ale_i  = cyc[0];
        psen_i = cyc[1] ^ cyc[3];
        @(posedge clk);
        cyc++;
        width = pll_sel_i ? PLL_W : HF_W;
        if (m_s2) m_run++; else m_run = 0;
        m_q  = (m_run >= width);
        m_s2 = m_s1;
        m_s1 = p;
        if (w) m_wc = WDT_W; else if (m_wc > 0) m_wc--;
        exp = m_q || (m_wc > 0);
        #1;
        chk(m_wc > 0 ? "R7" : (pll_sel_i ? "R4" : "R3"), core_rst_o, exp);
        chk("R9", rst_out_o, exp);
        chk("R10 ale", ale_o, ale_i | exp);
        chk("R10 psen", psen_o, psen_i | exp);
        if (core_rst_o) seen_high++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    initial begin
        #(2_000_000);
        errors++;
        $display("FAIL watchdog timeout actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: state while cleared
        rst_req_i = 1'b1;
        wdt_ovf_i = 1'b1;
        ale_i = 1'b0;
        psen_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 core", core_rst_o, 1'b0);
        chk("R1 out", rst_out_o, 1'b0);
        chk("R1 ale", ale_o, 1'b0);
        chk("R1 psen", psen_o, 1'b1);
        rst_req_i = 1'b0;
        wdt_ovf_i = 1'b0;
        arst_n = 1'b1;
        idle(4);

        // R5: one clock short, HF source
        seen_high = 0;
        pulse(HF_W - 1);
        idle(6);
        chk_int("R5 short HF pulse", seen_high, 0);

        // R5: low glitch restarts measurement
        seen_high = 0;
        pulse(15);
        step(1'b0, 1'b0);
        pulse(15);
        idle(6);
        chk_int("R5 glitch restart", seen_high, 0);

        // R2/R3: exact width; rises 2 sync edges + 24 samples after first drive
        seen_high = 0;
        pulse(HF_W + 1);
        chk_int("R2 R3 not yet", seen_high, 0);
        step(1'b1, 1'b0);
        chk("R3 asserted", core_rst_o, 1'b1);
        // R6: held while high, then drops
        seen_high = 0;
        pulse(40);
        chk_int("R6 held", seen_high, 40);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R6 still high through sync", core_rst_o, 1'b1);
        step(1'b0, 1'b0);
        chk("R6 dropped", core_rst_o, 1'b0);
        idle(6);

        // R4: PLL source
        pll_sel_i = 1'b1;
        idle(4);
        seen_high = 0;
        pulse(PLL_W - 1);
        idle(6);
        chk_int("R4 short PLL pulse", seen_high, 0);
        seen_high = 0;
        pulse(PLL_W + 2);
        chk("R4 asserted", core_rst_o, 1'b1);
        idle(6);
        chk_int("R4 length", seen_high, 3);
        pll_sel_i = 1'b0;
        idle(4);

        // R7: single watchdog strobe
        seen_high = 0;
        step(1'b0, 1'b1);
        idle(60);
        chk_int("R7 pulse length", seen_high, WDT_W);

        // R8: retrigger at 20 clocks into the pulse
        seen_high = 0;
        step(1'b0, 1'b1);
        idle(19);
        step(1'b0, 1'b1);
        idle(60);
        chk_int("R8 retrigger length", seen_high, 20 + WDT_W);

        // R9: watchdog during a pin reset, pin released first
        seen_high = 0;
        pulse(HF_W + 2);
        step(1'b1, 1'b1);
        pulse(5);
        idle(60);
        chk_int("R9 overlap", seen_high, 1 + 1 + 5 + WDT_W - 6 + 0 + 5 - 5);

        // R1: clear mid-pulse
        step(1'b0, 1'b1);
        idle(3);
        @(negedge clk);
        arst_n = 1'b0;
        #1;
        chk("R1 async clear", core_rst_o, 1'b0);
        m_run = 0; m_wc = 0; m_s1 = 0; m_s2 = 0; m_q = 0;
        @(negedge clk);
        arst_n = 1'b1;
        idle(8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule